// File: doc/BRIEF.md
# End-Around-Carry Packet Checksum Engine

This block computes the 16-bit checksum carried at the tail of every packet of a byte-serial tape protocol. The packet's bytes arrive one per accepted cycle. The first two bytes are the header, a flag byte and a count byte. The message bytes follow. Consecutive bytes are joined into 16-bit words, with the earlier byte in the low half. Each word is added into a running 16-bit sum, and any carry out of the top bit is folded back into bit 0. The header word therefore seeds the sum. If the packet has an odd length, the final byte is zero-extended and added in the same way.

When the byte marked as last is accepted, the finished sum appears on the result port one cycle later, together with a one-cycle valid pulse. A transmitter appends this value as two trailing bytes. A receiver can instead enable compare mode and present the checksum it received. The block then raises a mismatch flag with the result whenever the two values differ, and error-counting logic outside the block consumes that flag. A start pulse discards any partial packet, so packets may follow each other with no idle cycles between them.

Top module: `eac_checksum`

## Requirements
- R1: After reset, `out_valid` and `out_mismatch` are 0.
- R2: Bytes are paired in arrival order into words, with the earlier byte in bits 7:0 and the later byte in bits 15:8. For example, bytes 0x01 then 0x02 give the word 0x0201.
- R3: Each word is added to the running sum modulo 2^16, and a carry out of bit 15 is added back into bit 0. For example, 0xFFFF plus 0x0002 gives 0x0002.
- R4: When a packet has an odd number of bytes, the last byte is zero-extended to 16 bits (bits 15:8 are 0) and then added with end-around carry. A one-byte packet yields that byte as the sum.
- R5: `out_valid` is high for exactly the one cycle after the cycle in which a byte with `in_last` = 1 is accepted, and `out_sum` then holds the packet's sum until the next result.
- R6: A cycle with `start` = 1 discards the partial sum and any unpaired byte. If `in_valid` is also 1 in that cycle, the byte is the first byte of the new packet, so back-to-back packets need no idle cycle.
- R7: If `cmp_en` = 1 in the cycle of the last byte, `out_mismatch` is 1 together with `out_valid` exactly when the computed sum differs from `rx_sum`, which is sampled in that same cycle.
- R8: If `cmp_en` = 0 in the cycle of the last byte, `out_mismatch` stays 0 whatever `rx_sum` holds. `out_mismatch` is never 1 while `out_valid` is 0.
- R9: Cycles with `in_valid` = 0 and `start` = 0 have no effect: their `in_data` and `in_last` change neither the sum nor the pairing of bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new packet and discard partial state |
| in_valid | input | 1 | `in_data` carries a packet byte this cycle |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | This byte is the last of the packet |
| cmp_en | input | 1 | Compare the result against `rx_sum` |
| rx_sum | input | 16 | Received checksum, sampled with the last byte |
| out_valid | output | 1 | One-cycle pulse: `out_sum` is new |
| out_sum | output | 16 | Checksum of the last completed packet |
| out_mismatch | output | 1 | Computed sum differs from `rx_sum` (compare mode) |

## Verification
The bench uses byte pairs whose sum overflows bit 15. A design that dropped the end-around carry would report a result one lower, and a design that swapped the byte order inside a word would produce a byte-swapped sum. Odd-length and one-byte packets are included; a design that paired the final byte with stale held data would show nonzero upper bits. The bench aborts a packet mid-stream and then runs back-to-back packets with start on the first byte. A design that kept the held byte or the partial sum would corrupt the next result. Idle cycles carrying garbage data with the last flag set are inserted between bytes, and compare mode is driven with equal, unequal and disabled inputs, to catch a flag that is raised wrongly or never raised.

// File: rtl/eac_pkg.sv
package eac_pkg;
  parameter int BYTE_W = 8;
  localparam int SUM_W = 2 * BYTE_W;

  // ones'-complement addition: fold the carry out of the top bit into bit 0
  function automatic logic [SUM_W-1:0] eac_add(input logic [SUM_W-1:0] a,
                                               input logic [SUM_W-1:0] b);
    logic [SUM_W:0] raw;
    raw = {1'b0, a} + {1'b0, b};
    return raw[SUM_W-1:0] + {{(SUM_W-1){1'b0}}, raw[SUM_W]};
  endfunction
endpackage

// File: rtl/eac_pairer.sv
module eac_pairer
  import eac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              word_vld,
  output logic [SUM_W-1:0]  word,
  output logic              word_last
);
  logic              have_lo;
  logic [BYTE_W-1:0] lo_q;
  logic              have_eff;  // held byte still belongs to this packet

  assign have_eff  = have_lo && !start;
  assign word_vld  = in_valid && (have_eff || in_last);
  assign word_last = in_valid && in_last;
  assign word      = have_eff ? {in_data, lo_q} : {{BYTE_W{1'b0}}, in_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_lo <= 1'b0;
      lo_q    <= '0;
    end else if (in_valid) begin
      if (word_vld) begin
        have_lo <= 1'b0;
      end else begin
        have_lo <= 1'b1;
        lo_q    <= in_data;
      end
    end else if (start) begin
      have_lo <= 1'b0;
    end
  end

  p_start_drops_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_valid) |=> !have_lo);

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !start) |=> ($stable(have_lo) && $stable(lo_q)));

  p_odd_tail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && !have_lo) |-> (word[SUM_W-1:BYTE_W] == '0));
endmodule

// File: rtl/eac_accum.sv
module eac_accum
  import eac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             word_vld,
  input  logic [SUM_W-1:0] word,
  input  logic             word_last,
  input  logic             cmp_en,
  input  logic [SUM_W-1:0] rx_sum,
  output logic             out_valid,
  output logic [SUM_W-1:0] out_sum,
  output logic             out_mismatch
);
  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] acc_base;
  logic [SUM_W-1:0] acc_next;

  assign acc_base = start ? '0 : acc_q;
  assign acc_next = eac_add(acc_base, word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q        <= '0;
      out_valid    <= 1'b0;
      out_sum      <= '0;
      out_mismatch <= 1'b0;
    end else begin
      out_valid    <= 1'b0;
      out_mismatch <= 1'b0;
      if (word_vld) begin
        if (word_last) begin
          acc_q        <= '0;
          out_valid    <= 1'b1;
          out_sum      <= acc_next;
          out_mismatch <= cmp_en && (acc_next != rx_sum);
        end else begin
          acc_q <= acc_next;
        end
      end else if (start) begin
        acc_q <= '0;
      end
    end
  end

  p_start_clears_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !word_vld) |=> (acc_q == '0));

  p_zero_word_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !word_last && !start && word == '0) |=> $stable(acc_q));

  p_sum_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_sum) || $past(!rst_n)));
endmodule

// File: rtl/eac_checksum.sv
module eac_checksum
  import eac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              cmp_en,
  input  logic [SUM_W-1:0]  rx_sum,
  output logic              out_valid,
  output logic [SUM_W-1:0]  out_sum,
  output logic              out_mismatch
);
  logic             pair_vld;
  logic [SUM_W-1:0] pair_word;
  logic             pair_last;

  eac_pairer u_pair (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .word_vld(pair_vld), .word(pair_word), .word_last(pair_last)
  );

  eac_accum u_acc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .word_vld(pair_vld), .word(pair_word), .word_last(pair_last),
    .cmp_en(cmp_en), .rx_sum(rx_sum),
    .out_valid(out_valid), .out_sum(out_sum), .out_mismatch(out_mismatch)
  );

  p_result_follows_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_last));

  p_flag_only_with_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_mismatch |-> out_valid);

  p_flag_needs_compare_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_mismatch |-> $past(cmp_en));
endmodule

// File: tb/sim_eac_checksum.sv
`timescale 1ns/1ps
module sim_eac_checksum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        cmp_en = 1'b0;
  logic [15:0] rx_sum = '0;
  logic        out_valid;
  logic [15:0] out_sum;
  logic        out_mismatch;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [7:0]  pkt [0:31];
  int          pkt_len;
  logic [15:0] exp_sum_q [$];
  bit          exp_mis_q [$];
  string       exp_tag_q [$];
  logic [15:0] last_sum;

  always #2.5 clk = ~clk;

  eac_checksum u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .cmp_en(cmp_en), .rx_sum(rx_sum),
    .out_valid(out_valid), .out_sum(out_sum), .out_mismatch(out_mismatch)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // reference: whole-sum then fold, different from the per-word fold in the design
  function automatic logic [15:0] ref_sum();
    longint s = 0;
    for (int i = 0; i < pkt_len; i += 2) begin
      if (i + 1 < pkt_len) s += {pkt[i+1], pkt[i]};
      else                 s += {8'h00, pkt[i]};
    end
    while (s > 64'hFFFF) s = (s & 64'hFFFF) + (s >> 16);
    return s[15:0];
  endfunction

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start = 1'b0; in_valid = 1'b0;
      in_data = 8'hA5 ^ k[7:0]; in_last = 1'b1;  // garbage while idle (R9)
    end
  endtask

  task automatic send_pkt(input bit cmp, input logic [15:0] rx, input int gap,
                          input string tag);
    logic [15:0] e;
    e = ref_sum();
    for (int i = 0; i < pkt_len; i++) begin
      if (i > 0 && gap > 0) idle(gap);
      @(negedge clk);
      start = (i == 0); in_valid = 1'b1; in_data = pkt[i];
      in_last = (i == pkt_len - 1); cmp_en = cmp; rx_sum = rx;
      if (i == pkt_len - 1) begin
        exp_sum_q.push_back(e);
        exp_mis_q.push_back(cmp && (e != rx));
        exp_tag_q.push_back(tag);
      end
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_sum_q.size() == 0) begin
          check(1'b0, "R5 unexpected result", int'(out_sum), 0);
        end else begin
          logic [15:0] es;
          bit em;
          string t;
          es = exp_sum_q.pop_front(); em = exp_mis_q.pop_front(); t = exp_tag_q.pop_front();
          check(out_sum == es, t, int'(out_sum), int'(es));
          check(out_mismatch == em, {t, " mismatch flag R7 R8"}, int'(out_mismatch), int'(em));
          last_sum = out_sum;
        end
      end else begin
        if (out_mismatch) check(1'b0, "R8 flag without result", 1, 0);
      end
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=<50000", cycles);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(out_mismatch == 1'b0, "R1 out_mismatch after reset", int'(out_mismatch), 0);
    rst_n = 1'b1;
    idle(2);

    // R2: byte order inside a word
    pkt[0] = 8'h01; pkt[1] = 8'h02; pkt_len = 2;
    send_pkt(0, 16'h0, 0, "R2 little-endian pair");
    idle(3);
    check(out_sum == 16'h0201, "R2 direct value", int'(out_sum), 16'h0201);

    // R3: carry folds back
    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h02; pkt[3] = 8'h00; pkt_len = 4;
    send_pkt(0, 16'h0, 0, "R3 end-around carry");
    idle(3);
    check(out_sum == 16'h0002, "R3 direct value", int'(out_sum), 16'h0002);

    // R4: odd trailing byte
    pkt[0] = 8'h02; pkt[1] = 8'h01; pkt[2] = 8'hAB; pkt_len = 3;
    send_pkt(0, 16'h0, 0, "R4 odd tail");
    idle(3);
    check(out_sum == 16'h01AD, "R4 direct value", int'(out_sum), 16'h01AD);
    pkt[0] = 8'h80; pkt_len = 1;
    send_pkt(0, 16'h0, 0, "R4 single byte");
    idle(2);

    // R5: result held through idle cycles
    idle(5);
    check(out_valid == 1'b0, "R5 pulse ends", int'(out_valid), 0);
    check(out_sum == 16'h0080, "R5 sum held", int'(out_sum), 16'h0080);

    // R9: gaps with garbage between bytes
    pkt[0] = 8'h10; pkt[1] = 8'hF0; pkt[2] = 8'h33; pkt[3] = 8'hC4; pkt[4] = 8'h7E; pkt_len = 5;
    send_pkt(0, 16'h0, 2, "R9 idle gaps ignored");
    idle(2);

    // R6: abort mid-packet, then new packet
    @(negedge clk); start = 1'b1; in_valid = 1'b1; in_data = 8'hEE; in_last = 1'b0;
    @(negedge clk); start = 1'b0; in_data = 8'hDD;
    @(negedge clk); in_data = 8'h77;   // unpaired byte left behind
    pkt[0] = 8'h05; pkt[1] = 8'h00; pkt[2] = 8'h09; pkt_len = 3;
    send_pkt(0, 16'h0, 0, "R6 abort then restart");
    // R6: abort with held byte via start alone
    @(negedge clk); start = 1'b1; in_valid = 1'b1; in_data = 8'h44; in_last = 1'b0;
    @(negedge clk); start = 1'b1; in_valid = 1'b0;
    @(negedge clk); start = 1'b0; in_valid = 1'b1; in_data = 8'h12; in_last = 1'b1;
    exp_sum_q.push_back(16'h0012); exp_mis_q.push_back(1'b0); exp_tag_q.push_back("R6 start alone clears");
    idle(2);

    // R6: back-to-back packets, no idle
    for (int p = 0; p < 6; p++) begin
      pkt_len = 2 + p;
      for (int i = 0; i < pkt_len; i++) pkt[i] = 8'((p * 53 + i * 97 + 200) & 8'hFF);
      send_pkt(0, 16'h0, 0, "R6 back-to-back");
    end
    idle(2);

    // R7 / R8: compare mode
    pkt[0] = 8'h02; pkt[1] = 8'h04; pkt[2] = 8'h11; pkt[3] = 8'h22; pkt_len = 4;
    send_pkt(1, ref_sum(), 0, "R7 compare equal");
    send_pkt(1, ref_sum() ^ 16'h0100, 0, "R7 compare differ");
    send_pkt(0, 16'hBEEF, 0, "R8 compare disabled");
    idle(3);

    // longer random-ish packets with carries
    for (int p = 0; p < 10; p++) begin
      pkt_len = 20 + p;
      for (int i = 0; i < pkt_len; i++) pkt[i] = 8'((i * 37 + p * 11 + 190) & 8'hFF);
      send_pkt(p[0], 16'h1234, p % 2, "R3 long packet");
    end
    idle(4);

    check(exp_sum_q.size() == 0, "R5 all results seen", exp_sum_q.size(), 0);
    finish_up();
  end
endmodule